// File: doc/BRIEF.md
# Processor Privilege Mode Controller

This block holds the user-mode and virtual-mode state of a small 32-bit processor core and decides, cycle by cycle, whether execution leaves those modes or returns to them. The decode stage feeds it one-cycle event strobes: a debug reset, a non-maskable or hardware break, a hardware exception, an interrupt, a decoded branch-and-link with its target address, a decoded software break with its target address, and a decoded return-from-exception. A privileged write strobe loads the saved-mode bits, which is how a kernel prepares a later return into user or virtual mode.

When an exit is taken, the block clears both mode bits and copies their old values into the saved-mode bits. It also registers a two-bit vector select, which picks an offset of 0x0, 0x8, 0x10 or 0x18 above the configured vector base. A branch-and-link from user mode to base + 0x8 is turned into a system-call exception. Extended-address loads and stores are judged against the privilege configuration parameter. With a setting of 2 or 3 they pass without privilege and are flagged to bypass address translation. With a setting of 0 or 1, user-mode use of them is trapped.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a `dbg_rst` strobe, `user_mode`, `virt_mode`, `saved_user` and `saved_virt` are all 0. After `dbg_rst`, `vec_stb` is 1 for one cycle and `vec_sel` is 0 (offset 0x0). After `rst_n`, `vec_stb` and `syscall_stb` are 0.
- R2: An exit event is taken on a clock edge. In the next cycle `user_mode` and `virt_mode` are 0, `saved_user` and `saved_virt` hold the mode bits from before that edge, and `vec_stb` is 1.
- R3: When several events arrive in one cycle, only the highest-priority one is served: `dbg_rst`, then `brk_evt`, then `exc_evt`, then `irq_evt`, then the system call, then the software break. The mode bits are saved once. The `vec_sel` codes are: 0 = offset 0x0 (reset), 1 = offset 0x8 (hardware exception, system call, software break to +0x8), 2 = offset 0x10 (interrupt), 3 = offset 0x18 (break, software break to +0x18).
- R4: A `brl_evt` whose `brl_target` equals VEC_BASE + 0x8, taken while `user_mode` is 1, is an exit with code 1, and `syscall_stb` is 1 in the next cycle. Any other `brl_evt` changes no mode bit, no saved bit and no strobe.
- R5: A `swb_evt` whose `swb_target` equals VEC_BASE + 0x8 or VEC_BASE + 0x18 is an exit in either mode, with code 1 or code 3. Any other target is ignored.
- R6: A `rte_evt` with no exit in the same cycle reloads `user_mode` from `saved_user` and `virt_mode` from `saved_virt`, and clears both saved bits.
- R7: A `set_saved` strobe with no exit and no `rte_evt` in the same cycle loads `saved_user` from `set_user` and `saved_virt` from `set_virt`.
- R8: With PRIV_CFG of 2 or 3, `ext_acc` drives `mmu_bypass` high in the same cycle in either mode, and `priv_trap` stays low.
- R9: With PRIV_CFG of 0 or 1, `mmu_bypass` stays low. `priv_trap` is high in the same cycle exactly when `ext_acc` is 1 and `user_mode` is 1.
- R10: In a cycle after an edge on which no exit and no `dbg_rst` was taken, `vec_stb` and `syscall_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| dbg_rst | input | 1 | Debug reset strobe |
| brk_evt | input | 1 | Non-maskable or hardware break strobe |
| exc_evt | input | 1 | Hardware exception strobe |
| irq_evt | input | 1 | Interrupt strobe |
| brl_evt | input | 1 | Decoded branch-and-link strobe |
| brl_target | input | ADDR_W | Branch-and-link target address |
| swb_evt | input | 1 | Decoded software break strobe |
| swb_target | input | ADDR_W | Software break target address |
| rte_evt | input | 1 | Decoded return-from-exception strobe |
| set_saved | input | 1 | Privileged write of the saved-mode bits |
| set_user | input | 1 | Value written to saved_user |
| set_virt | input | 1 | Value written to saved_virt |
| ext_acc | input | 1 | Extended-address load or store in decode |
| user_mode | output | 1 | Current user-mode bit |
| virt_mode | output | 1 | Current virtual-mode bit |
| saved_user | output | 1 | Saved user-mode bit |
| saved_virt | output | 1 | Saved virtual-mode bit |
| vec_sel | output | 2 | Registered vector offset select (code times 0x8) |
| vec_stb | output | 1 | Registered strobe: a vector was selected |
| syscall_stb | output | 1 | Registered strobe: system-call exception |
| priv_trap | output | 1 | Privileged-instruction trap for ext_acc |
| mmu_bypass | output | 1 | Extended address used as physical address |

## Verification
The bench builds two copies of the block side by side with VEC_BASE = 0x100 and the same inputs. One has PRIV_CFG = 1 and the other PRIV_CFG = 3, so the trap branch and the bypass branch are both checked against the same mode state. From each of the sixteen combinations of current and saved mode bits, it drives every mix of the seven event strobes together with matching and non-matching branch and break targets. This reaches every priority collision, the privileged-mode system-call case, the ignored targets, and the interplay between return, saved-bit write and exit.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;

  typedef enum logic [1:0] {
    VEC_RST = 2'd0,
    VEC_EXC = 2'd1,
    VEC_IRQ = 2'd2,
    VEC_BRK = 2'd3
  } vec_sel_e;

  localparam int unsigned VEC_STRIDE = 8;

  function automatic int unsigned vec_offset(input vec_sel_e s);
    return int'(s) * VEC_STRIDE;
  endfunction

  function automatic logic cfg_unpriv_ext(input int unsigned cfg);
    return cfg >= 2;
  endfunction

endpackage

// File: rtl/priv_exit_arb.sv
module priv_exit_arb
  import priv_mode_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              dbg_rst,
  input  logic              brk_evt,
  input  logic              exc_evt,
  input  logic              irq_evt,
  input  logic              brl_evt,
  input  logic [ADDR_W-1:0] brl_target,
  input  logic              swb_evt,
  input  logic [ADDR_W-1:0] swb_target,
  input  logic              user_mode,
  output logic              exit_save,
  output logic              syscall,
  output vec_sel_e          cause
);

  function automatic logic at_offset(input logic [ADDR_W-1:0] tgt, input vec_sel_e s);
    return tgt == (VEC_BASE + ADDR_W'(vec_offset(s)));
  endfunction

  logic brl_sys, swb_lo, swb_hi;
  assign brl_sys = brl_evt && user_mode && at_offset(brl_target, VEC_EXC);
  assign swb_lo  = swb_evt && at_offset(swb_target, VEC_EXC);
  assign swb_hi  = swb_evt && at_offset(swb_target, VEC_BRK);

  always_comb begin
    exit_save = 1'b1;
    syscall   = 1'b0;
    cause     = VEC_RST;
    if (dbg_rst) begin
      exit_save = 1'b0;
    end else if (brk_evt) begin
      cause = VEC_BRK;
    end else if (exc_evt) begin
      cause = VEC_EXC;
    end else if (irq_evt) begin
      cause = VEC_IRQ;
    end else if (brl_sys) begin
      cause   = VEC_EXC;
      syscall = 1'b1;
    end else if (swb_lo) begin
      cause = VEC_EXC;
    end else if (swb_hi) begin
      cause = VEC_BRK;
    end else begin
      exit_save = 1'b0;
    end
  end

endmodule

// File: rtl/priv_ext_gate.sv
module priv_ext_gate
  import priv_mode_pkg::*;
#(
  parameter int unsigned PRIV_CFG = 0
) (
  input  logic ext_acc,
  input  logic user_mode,
  output logic priv_trap,
  output logic mmu_bypass
);

  generate
    if (cfg_unpriv_ext(PRIV_CFG)) begin : g_unpriv
      assign mmu_bypass = ext_acc;
      assign priv_trap  = 1'b0;
    end else begin : g_priv
      assign mmu_bypass = 1'b0;
      assign priv_trap  = ext_acc && user_mode;
    end
  endgenerate

endmodule

// File: rtl/priv_mode_regs.sv
module priv_mode_regs
  import priv_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dbg_rst,
  input  logic     exit_save,
  input  logic     syscall,
  input  vec_sel_e cause,
  input  logic     rte_evt,
  input  logic     set_saved,
  input  logic     set_user,
  input  logic     set_virt,
  output logic     user_mode,
  output logic     virt_mode,
  output logic     saved_user,
  output logic     saved_virt,
  output vec_sel_e vec_sel,
  output logic     vec_stb,
  output logic     syscall_stb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_mode   <= 1'b0;
      virt_mode   <= 1'b0;
      saved_user  <= 1'b0;
      saved_virt  <= 1'b0;
      vec_sel     <= VEC_RST;
      vec_stb     <= 1'b0;
      syscall_stb <= 1'b0;
    end else begin
      vec_stb     <= 1'b0;
      syscall_stb <= 1'b0;
      if (dbg_rst) begin
        user_mode  <= 1'b0;
        virt_mode  <= 1'b0;
        saved_user <= 1'b0;
        saved_virt <= 1'b0;
        vec_sel    <= VEC_RST;
        vec_stb    <= 1'b1;
      end else if (exit_save) begin
        saved_user  <= user_mode;
        saved_virt  <= virt_mode;
        user_mode   <= 1'b0;
        virt_mode   <= 1'b0;
        vec_sel     <= cause;
        vec_stb     <= 1'b1;
        syscall_stb <= syscall;
      end else if (rte_evt) begin
        user_mode  <= saved_user;
        virt_mode  <= saved_virt;
        saved_user <= 1'b0;
        saved_virt <= 1'b0;
      end else if (set_saved) begin
        saved_user <= set_user;
        saved_virt <= set_virt;
      end
    end
  end

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_mode_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int unsigned       PRIV_CFG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_rst,
  input  logic              brk_evt,
  input  logic              exc_evt,
  input  logic              irq_evt,
  input  logic              brl_evt,
  input  logic [ADDR_W-1:0] brl_target,
  input  logic              swb_evt,
  input  logic [ADDR_W-1:0] swb_target,
  input  logic              rte_evt,
  input  logic              set_saved,
  input  logic              set_user,
  input  logic              set_virt,
  input  logic              ext_acc,
  output logic              user_mode,
  output logic              virt_mode,
  output logic              saved_user,
  output logic              saved_virt,
  output logic [1:0]        vec_sel,
  output logic              vec_stb,
  output logic              syscall_stb,
  output logic              priv_trap,
  output logic              mmu_bypass
);

  logic     exit_save;
  logic     syscall;
  vec_sel_e cause;
  vec_sel_e vec_sel_q;

  priv_exit_arb #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_arb (
    .dbg_rst    (dbg_rst),
    .brk_evt    (brk_evt),
    .exc_evt    (exc_evt),
    .irq_evt    (irq_evt),
    .brl_evt    (brl_evt),
    .brl_target (brl_target),
    .swb_evt    (swb_evt),
    .swb_target (swb_target),
    .user_mode  (user_mode),
    .exit_save  (exit_save),
    .syscall    (syscall),
    .cause      (cause)
  );

  priv_mode_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_rst     (dbg_rst),
    .exit_save   (exit_save),
    .syscall     (syscall),
    .cause       (cause),
    .rte_evt     (rte_evt),
    .set_saved   (set_saved),
    .set_user    (set_user),
    .set_virt    (set_virt),
    .user_mode   (user_mode),
    .virt_mode   (virt_mode),
    .saved_user  (saved_user),
    .saved_virt  (saved_virt),
    .vec_sel     (vec_sel_q),
    .vec_stb     (vec_stb),
    .syscall_stb (syscall_stb)
  );

  assign vec_sel = vec_sel_q;

  priv_ext_gate #(.PRIV_CFG(PRIV_CFG)) u_ext (
    .ext_acc    (ext_acc),
    .user_mode  (user_mode),
    .priv_trap  (priv_trap),
    .mmu_bypass (mmu_bypass)
  );

endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_rst,
  input logic       exit_save,
  input logic       syscall,
  input logic       rte_evt,
  input logic       ext_acc,
  input logic       user_mode,
  input logic       virt_mode,
  input logic       saved_user,
  input logic       saved_virt,
  input logic [1:0] vec_sel,
  input logic       vec_stb,
  input logic       syscall_stb,
  input logic       priv_trap,
  input logic       mmu_bypass
);

  // R1
  dbg_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rst |=> (!user_mode && !virt_mode && !saved_user && !saved_virt && vec_stb && vec_sel == 2'd0));

  // R2
  exit_saves_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_save |=> (!user_mode && !virt_mode && vec_stb &&
                   saved_user == $past(user_mode) && saved_virt == $past(virt_mode)));

  // R4
  syscall_from_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_stb |-> ($past(user_mode) && vec_stb && vec_sel == 2'd1));

  // R6
  rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rte_evt && !exit_save && !dbg_rst) |=>
      (user_mode == $past(saved_user) && virt_mode == $past(saved_virt) && !saved_user && !saved_virt));

  // R8
  bypass_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_bypass |-> (ext_acc && !priv_trap));

  // R9
  trap_needs_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_trap |-> (ext_acc && user_mode && !mmu_bypass));

  // R10
  quiet_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exit_save && !dbg_rst) |=> (!vec_stb && !syscall_stb));

  // R3
  syscall_only_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syscall |-> exit_save);

endmodule

bind priv_mode_ctrl priv_mode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_rst     (dbg_rst),
  .exit_save   (exit_save),
  .syscall     (syscall),
  .rte_evt     (rte_evt),
  .ext_acc     (ext_acc),
  .user_mode   (user_mode),
  .virt_mode   (virt_mode),
  .saved_user  (saved_user),
  .saved_virt  (saved_virt),
  .vec_sel     (vec_sel),
  .vec_stb     (vec_stb),
  .syscall_stb (syscall_stb),
  .priv_trap   (priv_trap),
  .mmu_bypass  (mmu_bypass)
);

// File: tb/priv_mode_ctrl_bench.sv
module priv_mode_ctrl_bench;

  localparam int unsigned AW   = 32;
  localparam logic [AW-1:0] BASE = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_rst = 0, brk_evt = 0, exc_evt = 0, irq_evt = 0;
  logic brl_evt = 0, swb_evt = 0, rte_evt = 0, set_saved = 0;
  logic set_user = 0, set_virt = 0, ext_acc = 0;
  logic [AW-1:0] brl_target = '0, swb_target = '0;

  logic um, vm, su, sv, stb, sys, trap1, byp1, trap3, byp3;
  logic um3, vm3, su3, sv3, stb3, sys3;
  logic [1:0] vsel, vsel3;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // model state
  logic m_um = 0, m_vm = 0, m_su = 0, m_sv = 0, m_stb = 0, m_sys = 0;
  logic [1:0] m_sel = 0;

  always #10 clk = ~clk;

  priv_mode_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE), .PRIV_CFG(1)) u_priv_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .dbg_rst(dbg_rst), .brk_evt(brk_evt), .exc_evt(exc_evt),
    .irq_evt(irq_evt), .brl_evt(brl_evt), .brl_target(brl_target), .swb_evt(swb_evt),
    .swb_target(swb_target), .rte_evt(rte_evt), .set_saved(set_saved), .set_user(set_user),
    .set_virt(set_virt), .ext_acc(ext_acc), .user_mode(um), .virt_mode(vm), .saved_user(su),
    .saved_virt(sv), .vec_sel(vsel), .vec_stb(stb), .syscall_stb(sys), .priv_trap(trap1),
    .mmu_bypass(byp1));

  priv_mode_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE), .PRIV_CFG(3)) u_priv_mode_ctrl_byp (
    .clk(clk), .rst_n(rst_n), .dbg_rst(dbg_rst), .brk_evt(brk_evt), .exc_evt(exc_evt),
    .irq_evt(irq_evt), .brl_evt(brl_evt), .brl_target(brl_target), .swb_evt(swb_evt),
    .swb_target(swb_target), .rte_evt(rte_evt), .set_saved(set_saved), .set_user(set_user),
    .set_virt(set_virt), .ext_acc(ext_acc), .user_mode(um3), .virt_mode(vm3), .saved_user(su3),
    .saved_virt(sv3), .vec_sel(vsel3), .vec_stb(stb3), .syscall_stb(sys3), .priv_trap(trap3),
    .mmu_bypass(byp3));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // brk kind: 0 none, 1 base+8, 2 base+4 ; swb kind: 0 none, 1 +8, 2 +0x18, 3 +0x10
  task automatic apply(input logic d, input logic b, input logic e, input logic i,
                       input int bk, input int sk, input logic r, input logic s,
                       input logic s_u, input logic s_v);
    string tag;
    logic take;
    dbg_rst = d; brk_evt = b; exc_evt = e; irq_evt = i;
    brl_evt = (bk != 0);
    brl_target = (bk == 1) ? BASE + 32'h8 : BASE + 32'h4;
    swb_evt = (sk != 0);
    swb_target = (sk == 1) ? BASE + 32'h8 : (sk == 2) ? BASE + 32'h18 : BASE + 32'h10;
    rte_evt = r; set_saved = s; set_user = s_u; set_virt = s_v;
    // model
    take = 1'b1; m_sys = 1'b0; m_stb = 1'b0;
    if (d) tag = "R1";
    else if ((b + e + i) > 1) tag = "R3";
    else if (b || e || i) tag = "R2";
    else if (bk != 0) tag = "R4";
    else if (sk != 0) tag = "R5";
    else if (r) tag = "R6";
    else if (s) tag = "R7";
    else tag = "R10";
    if (d) begin
      take = 1'b0;
      m_um = 0; m_vm = 0; m_su = 0; m_sv = 0; m_sel = 2'd0; m_stb = 1'b1;
    end else begin
      if (b) m_sel = 2'd3;
      else if (e) m_sel = 2'd1;
      else if (i) m_sel = 2'd2;
      else if (bk == 1 && m_um) begin m_sel = 2'd1; m_sys = 1'b1; end
      else if (sk == 1) m_sel = 2'd1;
      else if (sk == 2) m_sel = 2'd3;
      else take = 1'b0;
      if (take) begin
        m_su = m_um; m_sv = m_vm; m_um = 0; m_vm = 0; m_stb = 1'b1;
        if ((b + e + i) + ((bk == 1 && m_su) ? 1 : 0) + ((sk == 1 || sk == 2) ? 1 : 0) > 1) tag = "R3";
      end else if (r) begin
        m_um = m_su; m_vm = m_sv; m_su = 0; m_sv = 0;
      end else if (s) begin
        m_su = s_u; m_sv = s_v;
      end
    end
    @(posedge clk); #1;
    dbg_rst = 0; brk_evt = 0; exc_evt = 0; irq_evt = 0; brl_evt = 0; swb_evt = 0;
    rte_evt = 0; set_saved = 0;
    check(tag, "user_mode", um, m_um);
    check(tag, "virt_mode", vm, m_vm);
    check(tag, "saved_user", su, m_su);
    check(tag, "saved_virt", sv, m_sv);
    check(tag, "vec_stb", stb, m_stb);
    check(tag, "syscall_stb", sys, m_sys);
    if (m_stb) check(tag, "vec_sel", vsel, m_sel);
    check(tag, "copy_agree", {um3, vm3, su3, sv3, stb3, sys3}, {um, vm, su, sv, stb, sys});
  endtask

  task automatic set_state(input logic u, input logic v, input logic s_u, input logic s_v);
    apply(0, 0, 0, 0, 0, 0, 0, 1, u, v);
    apply(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 1, s_u, s_v);
  endtask

  initial begin
    #5;
    check("R1", "reset user_mode", um, 0);
    check("R1", "reset virt_mode", vm, 0);
    check("R1", "reset saved", {su, sv}, 0);
    check("R1", "reset strobes", {stb, sys}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // extended-address access in every mode state (R8, R9)
    for (int st = 0; st < 4; st++) begin
      set_state(st[0], st[1], 0, 0);
      ext_acc = 1'b1; #1;
      check("R9", "priv_trap cfg1", trap1, st[0]);
      check("R9", "mmu_bypass cfg1", byp1, 0);
      check("R8", "mmu_bypass cfg3", byp3, 1);
      check("R8", "priv_trap cfg3", trap3, 0);
      ext_acc = 1'b0; #1;
      check("R9", "idle trap cfg1", trap1, 0);
      check("R8", "idle bypass cfg3", byp3, 0);
    end

    // near-exhaustive event sweep from every mode state
    for (int st = 0; st < 16; st++) begin
      for (int ev = 0; ev < 768; ev++) begin
        set_state(st[0], st[1], st[2], st[3]);
        apply(ev[0], ev[1], ev[2], ev[3], ev[5:4] % 3, ev[7:6], ev[8], ev[9],
              ~st[2], ~st[3]);
      end
    end
    finish_run();
  end

endmodule